// File: doc/BRIEF.md
# CAN Identifier Acceptance Mask Filter

This block keeps three programmable 32-bit acceptance masks and uses them to decide whether an incoming CAN frame identifier is accepted by a message buffer. One mask is shared by most buffers. The other two belong to two dedicated buffers, indices 14 and 15 by default. The receive logic presents the received identifier together with its IDE and RTR bits. It also presents the stored identifier, IDE and RTR of the candidate buffer and that buffer's index. The block returns a single acceptance flag in the same cycle.

The mask bits are not a plain bitwise mask. The identifier-extension flag is always compared. The two RTR/SRR positions are never compared and always read back as zero. The low 18 mask bits apply only to extended-format frames. A remote request frame is never accepted. A host writes and reads the masks through a small register port that takes a 2-bit slot address.

Top module: `can_id_mask_filter`

## Requirements
- R1: After a synchronous, active-high reset, all three masks read as 0xFFEF_FFFE.
- R2: A read from slot 0 (shared), 1 (first dedicated buffer) or 2 (second dedicated buffer) returns the stored mask. In that value bit 19 is always 1 and bits 20 and 0 are always 0, whatever value was written.
- R3: A write to slot 3 changes no mask. hostRdData is 0 when slot 3 is read and whenever hostRdEn is low.
- R4: A mask write takes effect from the clock edge on which it is accepted. A compare made in the same cycle as the write still uses the old mask.
- R5: Mask bits 31..21 control identifier bits 28..18 for both frame formats. Where a mask bit is 1, the received bit must equal the buffer bit. Where it is 0, that bit is ignored.
- R6: For an extended frame (rxIde = 1), mask bits 18..1 control identifier bits 17..0 in the same way.
- R7: For a standard frame (rxIde = 0), identifier bits 17..0 of both the received and the buffer identifier are ignored, even where mask bits 18..1 are set.
- R8: When rxIde differs from bufIde, matchHit is 0 for every mask value.
- R9: When rxRtr is 1, matchHit is 0 for every mask and identifier value.
- R10: bufRtr has no effect on matchHit.
- R11: A buffer index equal to BUF_A_IDX (14) selects mask slot 1. A buffer index equal to BUF_B_IDX (15) selects slot 2. Every other index selects the shared slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read enable |
| hostAddr | input | ADDR_W (2) | Mask slot select: 0 shared, 1 and 2 dedicated, 3 unused |
| hostWrData | input | 32 | Mask write value |
| hostRdData | output | 32 | Mask read value, combinational |
| rxId | input | 29 | Received identifier; standard frames use bits 28..18 |
| rxIde | input | 1 | Received frame is in extended format |
| rxRtr | input | 1 | Received frame is a remote request |
| bufId | input | 29 | Identifier stored in the candidate buffer |
| bufIde | input | 1 | Extended-format flag of the buffer |
| bufRtr | input | 1 | RTR bit of the buffer (not compared) |
| bufIndex | input | BUF_IDX_W (4) | Index of the candidate buffer |
| matchHit | output | 1 | The received frame is accepted by the buffer |

## Verification
The assertions assume that rst, hostWrEn, hostRdEn and hostAddr hold known values at every rising edge. They also assume that the compare inputs settle before the edge on which the acceptance properties are sampled. The bench drives every input just after a falling edge and samples outputs a short delay later, well away from any rising edge. It issues at most one host access per cycle and holds the compare inputs steady across the write cycle used to show the one-edge mask update.

// File: rtl/can_id_mask_pkg.sv
package can_id_mask_pkg;

  localparam int MASK_W    = 32;
  localparam int ID_W      = 29;
  localparam int STD_W     = 11;
  localparam int EXT_W     = 18;
  localparam int NUM_MASKS = 3;
  localparam int SLOT_W    = $clog2(NUM_MASKS + 1);

  // Bit positions the comparator depends on
  localparam int STD_MSB = 31;
  localparam int STD_LSB = STD_MSB - STD_W + 1;   // 21
  localparam int SRR_POS = STD_LSB - 1;           // 20
  localparam int IDE_POS = SRR_POS - 1;           // 19
  localparam int EXT_MSB = IDE_POS - 1;           // 18
  localparam int EXT_LSB = EXT_MSB - EXT_W + 1;   // 1
  localparam int RTR_POS = EXT_LSB - 1;           // 0

  localparam logic [MASK_W-1:0] MASK_RST = 32'hFFEF_FFFE;

  typedef struct packed {
    logic [NUM_MASKS-1:0] wrStrobe;
    logic                 rdValid;
    logic [SLOT_W-1:0]    rdSlot;
    logic [SLOT_W-1:0]    cmpSlot;
  } maskCtl_t;

  // Apply the fixed bits of a mask value
  function automatic logic [MASK_W-1:0] fixMask(input logic [MASK_W-1:0] raw);
    logic [MASK_W-1:0] v;
    v          = raw;
    v[IDE_POS] = 1'b1;
    v[SRR_POS] = 1'b0;
    v[RTR_POS] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/can_id_mask_ctl.sv
module can_id_mask_ctl
  import can_id_mask_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int BUF_IDX_W = 4,
  parameter int BUF_A_IDX = 14,
  parameter int BUF_B_IDX = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [BUF_IDX_W-1:0] bufIndex,
  output maskCtl_t             ctl
);

  logic slotValid;
  assign slotValid = (int'(hostAddr) < NUM_MASKS);

  // One write strobe per mask slot
  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_wr
    assign ctl.wrStrobe[g] = hostWrEn && (int'(hostAddr) == g);
  end

  assign ctl.rdValid = hostRdEn && slotValid;
  assign ctl.rdSlot  = SLOT_W'(hostAddr);

  // Buffer index to mask slot
  always_comb begin
    if (int'(bufIndex) == BUF_A_IDX)      ctl.cmpSlot = SLOT_W'(1);
    else if (int'(bufIndex) == BUF_B_IDX) ctl.cmpSlot = SLOT_W'(2);
    else                                  ctl.cmpSlot = SLOT_W'(0);
  end

  // R3: the unused slot raises no write strobe
  a_r3_unused_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (hostWrEn && !slotValid) |-> (ctl.wrStrobe == '0));

  // R2: at most one slot written per cycle
  a_r2_single_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl.wrStrobe));

  // R11: buffer indices outside the two dedicated ones use the shared slot
  a_r11_shared_slot: assert property (@(posedge clk) disable iff (rst)
    ((int'(bufIndex) != BUF_A_IDX) && (int'(bufIndex) != BUF_B_IDX)) |-> (ctl.cmpSlot == '0));

endmodule

// File: rtl/can_id_mask_dp.sv
module can_id_mask_dp
  import can_id_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  maskCtl_t          ctl,
  input  logic [MASK_W-1:0] hostWrData,
  output logic [MASK_W-1:0] hostRdData,
  input  logic [ID_W-1:0]   rxId,
  input  logic              rxIde,
  input  logic              rxRtr,
  input  logic [ID_W-1:0]   bufId,
  input  logic              bufIde,
  input  logic              bufRtr,
  output logic              matchHit
);

  logic [MASK_W-1:0] maskReg [NUM_MASKS];

  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)                   maskReg[g] <= MASK_RST;
      else if (ctl.wrStrobe[g])  maskReg[g] <= fixMask(hostWrData);
    end

    // R1: masks hold their reset value right after reset
    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (maskReg[g] == MASK_RST));

    // R4: a write lands on the next edge with the fixed bits applied
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
      ctl.wrStrobe[g] |=> (maskReg[g] == fixMask($past(hostWrData))));

    // R3: a slot not strobed keeps its value
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      !ctl.wrStrobe[g] |=> $stable(maskReg[g]));
  end

  // Host read path
  always_comb begin
    hostRdData = '0;
    if (ctl.rdValid) begin
      for (int i = 0; i < NUM_MASKS; i++) begin
        if (int'(ctl.rdSlot) == i) hostRdData = maskReg[i];
      end
    end
  end

  // Compare path
  logic [MASK_W-1:0] selMask;
  logic [STD_W-1:0]  stdDiff;
  logic [EXT_W-1:0]  extDiff;
  logic              ideSame;

  always_comb begin
    selMask = maskReg[0];
    for (int i = 1; i < NUM_MASKS; i++) begin
      if (int'(ctl.cmpSlot) == i) selMask = maskReg[i];
    end
  end

  assign stdDiff  = (rxId[ID_W-1 -: STD_W] ^ bufId[ID_W-1 -: STD_W]) & selMask[STD_MSB:STD_LSB];
  assign extDiff  = (rxId[EXT_W-1:0] ^ bufId[EXT_W-1:0]) & selMask[EXT_MSB:EXT_LSB];
  assign ideSame  = (rxIde == bufIde) || !selMask[IDE_POS];
  assign matchHit = !rxRtr && ideSame && (stdDiff == '0) && (!rxIde || (extDiff == '0));

  logic unusedBufRtr;
  assign unusedBufRtr = bufRtr;

  // R9: remote frames are never accepted
  a_r9_remote_rejected: assert property (@(posedge clk) disable iff (rst)
    rxRtr |-> !matchHit);

  // R8: a format mismatch is never accepted
  a_r8_ide_mismatch: assert property (@(posedge clk) disable iff (rst)
    (rxIde != bufIde) |-> !matchHit);

  // R2: fixed bits on every read
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    ctl.rdValid |-> (hostRdData[IDE_POS] && !hostRdData[SRR_POS] && !hostRdData[RTR_POS]));

  // R3: no read enable, no data
  a_r3_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !ctl.rdValid |-> (hostRdData == '0));

endmodule

// File: rtl/can_id_mask_filter.sv
module can_id_mask_filter
  import can_id_mask_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int BUF_IDX_W = 4,
  parameter int BUF_A_IDX = 14,
  parameter int BUF_B_IDX = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [31:0]          hostWrData,
  output logic [31:0]          hostRdData,
  input  logic [28:0]          rxId,
  input  logic                 rxIde,
  input  logic                 rxRtr,
  input  logic [28:0]          bufId,
  input  logic                 bufIde,
  input  logic                 bufRtr,
  input  logic [BUF_IDX_W-1:0] bufIndex,
  output logic                 matchHit
);

  maskCtl_t ctl;

  can_id_mask_ctl #(
    .ADDR_W    (ADDR_W),
    .BUF_IDX_W (BUF_IDX_W),
    .BUF_A_IDX (BUF_A_IDX),
    .BUF_B_IDX (BUF_B_IDX)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .hostWrEn (hostWrEn),
    .hostRdEn (hostRdEn),
    .hostAddr (hostAddr),
    .bufIndex (bufIndex),
    .ctl      (ctl)
  );

  can_id_mask_dp u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .rxId       (rxId),
    .rxIde      (rxIde),
    .rxRtr      (rxRtr),
    .bufId      (bufId),
    .bufIde     (bufIde),
    .bufRtr     (bufRtr),
    .matchHit   (matchHit)
  );

endmodule

// File: tb/can_id_mask_filter_tb.sv
module can_id_mask_filter_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        hostWrEn, hostRdEn;
  logic [1:0]  hostAddr;
  logic [31:0] hostWrData, hostRdData;
  logic [28:0] rxId, bufId;
  logic        rxIde, rxRtr, bufIde, bufRtr;
  logic [3:0]  bufIndex;
  logic        matchHit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  can_id_mask_filter u_dut (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .rxId(rxId), .rxIde(rxIde), .rxRtr(rxRtr), .bufId(bufId),
    .bufIde(bufIde), .bufRtr(bufRtr), .bufIndex(bufIndex), .matchHit(matchHit)
  );

  localparam logic [28:0] ID_A = 29'h0ACE_1357;
  localparam logic [28:0] ALL1 = 29'h1FFF_FFFF;

  typedef struct packed {
    logic [3:0]  idx;
    logic [28:0] rId;
    logic        rIde;
    logic        rRtr;
    logic [28:0] bId;
    logic        bIde;
    logic        bRtr;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  // Masks in force: slot0 reads 0xFFEFFFFE, slot1 0x00080000, slot2 0xFFE80000
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  ID_A,            1'b1, 1'b0, ID_A,        1'b1, 1'b0, 1'b1, 4'd6},  // R6 exact ext
    '{4'd0,  ID_A ^ 29'd1,    1'b1, 1'b0, ID_A,        1'b1, 1'b0, 1'b0, 4'd6},  // R6 low bit differs
    '{4'd0,  ID_A ^ 29'd1,    1'b0, 1'b0, ID_A,        1'b0, 1'b0, 1'b1, 4'd7},  // R7 std ignores low
    '{4'd0,  ID_A ^ (29'd1 << 18), 1'b0, 1'b0, ID_A,   1'b0, 1'b0, 1'b0, 4'd5},  // R5 std bit differs
    '{4'd0,  ID_A,            1'b1, 1'b1, ID_A,        1'b1, 1'b0, 1'b0, 4'd9},  // R9 remote
    '{4'd0,  ID_A,            1'b0, 1'b0, ID_A,        1'b1, 1'b0, 1'b0, 4'd8},  // R8 IDE differs
    '{4'd0,  ID_A,            1'b1, 1'b0, ID_A,        1'b1, 1'b1, 1'b1, 4'd10}, // R10 bufRtr set
    '{4'd14, ID_A,            1'b1, 1'b0, ID_A ^ ALL1, 1'b1, 1'b0, 1'b1, 4'd11}, // R11 slot1 all don't care
    '{4'd14, ID_A,            1'b1, 1'b0, ID_A,        1'b0, 1'b0, 1'b0, 4'd8},  // R8 slot1 IDE
    '{4'd14, ID_A,            1'b0, 1'b1, ID_A ^ ALL1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 slot1 remote
    '{4'd15, ID_A ^ 29'h3FFFF,1'b1, 1'b0, ID_A,        1'b1, 1'b0, 1'b1, 4'd11}, // R11 slot2 low don't care
    '{4'd15, ID_A ^ (29'd1 << 28), 1'b1, 1'b0, ID_A,   1'b1, 1'b0, 1'b0, 4'd5},  // R5 slot2 top bit
    '{4'd13, ID_A ^ 29'd1,    1'b1, 1'b0, ID_A,        1'b1, 1'b0, 1'b0, 4'd11}  // R11 idx13 shared
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = a;
    #2 d = hostRdData;
    hostRdEn = 1'b0;
  endtask

  task automatic setCmp(input logic [3:0] idx, input logic [28:0] r, input logic ri, input logic rr,
                        input logic [28:0] b, input logic bi, input logic br);
    bufIndex = idx; rxId = r; rxIde = ri; rxRtr = rr; bufId = b; bufIde = bi; bufRtr = br;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst = 1'b1; hostWrEn = 1'b0; hostRdEn = 1'b0; hostAddr = '0; hostWrData = '0;
    setCmp(4'd0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    for (int s = 0; s < 3; s++) begin
      hostRead(2'(s), rd);
      check("R1 reset mask", rd, 32'hFFEF_FFFE);
    end
    // R1: reset mask compares all ext bits
    @(negedge clk); setCmp(4'd0, ID_A ^ 29'd1, 1'b1, 1'b0, ID_A, 1'b1, 1'b0);
    #2 check("R1 reset mask ext compare", {31'd0, matchHit}, 32'd0);

    // R2: writes and readback with fixed bits
    hostWrite(2'd0, 32'hFFFF_FFFF);
    hostWrite(2'd1, 32'h0000_0000);
    hostWrite(2'd2, 32'hFFE0_0000);
    hostRead(2'd0, rd); check("R2 slot0 readback", rd, 32'hFFEF_FFFE);
    hostRead(2'd1, rd); check("R2 slot1 readback", rd, 32'h0008_0000);
    hostRead(2'd2, rd); check("R2 slot2 readback", rd, 32'hFFE8_0000);

    // R3: unused slot and idle read
    hostWrite(2'd3, 32'h1234_5678);
    hostRead(2'd3, rd); check("R3 slot3 reads zero", rd, 32'h0);
    hostRead(2'd0, rd); check("R3 slot0 untouched", rd, 32'hFFEF_FFFE);
    hostRead(2'd1, rd); check("R3 slot1 untouched", rd, 32'h0008_0000);
    hostRead(2'd2, rd); check("R3 slot2 untouched", rd, 32'hFFE8_0000);
    @(negedge clk); hostAddr = 2'd0; hostRdEn = 1'b0;
    #2 check("R3 idle read zero", hostRdData, 32'h0);

    // Vector table: R5..R11
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      setCmp(VECS[i].idx, VECS[i].rId, VECS[i].rIde, VECS[i].rRtr, VECS[i].bId, VECS[i].bIde, VECS[i].bRtr);
      #2 check($sformatf("R%0d vector %0d", VECS[i].req, i), {31'd0, matchHit}, {31'd0, VECS[i].exp});
    end

    // R4: write slot0 to ignore low bits; old mask applies until the edge
    @(negedge clk);
    setCmp(4'd0, ID_A ^ 29'd1, 1'b1, 1'b0, ID_A, 1'b1, 1'b0);
    hostWrEn = 1'b1; hostAddr = 2'd0; hostWrData = 32'hFFE0_0000;
    #2 check("R4 old mask same cycle", {31'd0, matchHit}, 32'd0);
    @(negedge clk); hostWrEn = 1'b0;
    #2 check("R4 new mask after edge", {31'd0, matchHit}, 32'd1);

    // R5: top mask bit cleared makes bit 28 don't care
    hostWrite(2'd0, 32'h7FE0_0000);
    @(negedge clk); setCmp(4'd3, ID_A ^ (29'd1 << 28), 1'b0, 1'b0, ID_A, 1'b0, 1'b0);
    #2 check("R5 cleared mask bit ignored", {31'd0, matchHit}, 32'd1);
    @(negedge clk); setCmp(4'd3, ID_A ^ (29'd1 << 27), 1'b0, 1'b0, ID_A, 1'b0, 1'b0);
    #2 check("R5 set mask bit compared", {31'd0, matchHit}, 32'd0);

    // R7: std frame ignores low bits even with all ext mask bits set
    hostWrite(2'd0, 32'hFFFF_FFFF);
    @(negedge clk); setCmp(4'd0, ID_A ^ 29'h3FFFF, 1'b0, 1'b0, ID_A, 1'b0, 1'b0);
    #2 check("R7 std low bits ignored", {31'd0, matchHit}, 32'd1);

    // R8: IDE compared even when written mask bit 19 is 0 (slot1 written 0)
    @(negedge clk); setCmp(4'd14, ID_A, 1'b1, 1'b0, ID_A, 1'b0, 1'b0);
    #2 check("R8 IDE forced compare", {31'd0, matchHit}, 32'd0);

    // R1: second reset restores masks
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    hostRead(2'd1, rd); check("R1 reset after write", rd, 32'hFFEF_FFFE);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule